// File: doc/BRIEF.md
# Sample-Queued Pulse-Width Modulator

This block produces one pulse-width modulated output from a peripheral clock. Software programs it over a simple register bus: a valid/write strobe with a byte address, 32-bit write data and a combinational read-data return. A free-running counter, slowed by a programmable prescaler, steps through a cycle of the programmed period plus two counts. The output is active while the counter is below the duty value in use. The polarity bit flips that active level.

Duty values do not act on the output directly. Each one is pushed into a short queue of samples. The generator takes the next sample only when a cycle ends, so a new duty value can never cut into a cycle that is already running. If the queue is empty at that point, the last value stays in use. The status register tells software how many queue slots are free and whether a write was lost. A self-clearing reset bit returns every register and the queue to their defaults.

Top module: `sampled_pwm`

## Requirements
- R1: After reset: control reads 0, period reads 0, status reads 0x40 (four free slots, no overflow), and the output is 0.
- R2: With the prescaler at divide-by-one, the live counter (offset 0x14) steps 0,1,...,P+1 on successive clocks and then returns to 0, where P is the period register (offset 0x10). A cycle is therefore P+2 clocks.
- R3: A period write above 0xFFFD is stored as 0xFFFD. Smaller values are stored as written.
- R4: Control bits [11:8] hold the divide ratio minus one. The counter advances once every (field+1) clocks.
- R5: While the enable bit (control bit 0) is 0, the output is 0 whatever the polarity or duty, and the counter is held at 0.
- R6: Control bit 1 set inverts the output while enabled: it is then active for P+2-D clocks of each cycle instead of D.
- R7: Writing control with bit 3 set starts a soft reset. Bit 3 reads 1 for exactly one cycle, then clears itself. All registers, the duty in use, the overflow flag and the queue then return to their R1 values.
- R8: Writes to offset 0x0C push a duty value into a 4-entry queue. Status bits [6:4] give the number of free entries.
- R9: A duty write while the queue is full is dropped and never reaches the output. It sets status bit 0, which stays set until a soft reset.
- R10: A duty written while a cycle is running does not change that cycle. Reading offset 0x0C returns the duty in use, which changes only when the counter is 0.
- R11: When the block is enabled it loads the oldest queued entry. At each cycle end it loads the next entry in write order. With the queue empty it keeps the duty it has.
- R12: The output is active while the counter is below the duty. A duty of 0 gives a constant inactive output, and a duty of P+2 or more gives a constant active output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
The assertions take for granted that reset is held over the first clocks, so the counter, the duty in use and the queue start from known values. They also assume that every write is a one-cycle strobe sampled at a rising edge, so the soft-reset pulse, the overflow flag and the boundary-only duty change can each be checked one edge at a time. The stimulus drives every bus signal at falling edges and lowers the strobe after a single cycle. It changes duty only through queue writes, and it finds each cycle boundary by reading the live counter rather than by assuming a phase. Mid-cycle writes are issued from a parallel process while the output is being counted.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

    localparam int BUS_DW = 32;
    localparam int BUS_AW = 5;

    localparam logic [BUS_AW-1:0] OFS_CTRL = 5'h00;
    localparam logic [BUS_AW-1:0] OFS_STAT = 5'h04;
    localparam logic [BUS_AW-1:0] OFS_DUTY = 5'h0C;
    localparam logic [BUS_AW-1:0] OFS_PER  = 5'h10;
    localparam logic [BUS_AW-1:0] OFS_CNT  = 5'h14;

    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_POL_BIT  = 1;
    localparam int CTL_SRST_BIT = 3;
    localparam int CTL_PRE_LSB  = 8;

    localparam int STA_OVF_BIT  = 0;
    localparam int STA_FREE_LSB = 4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_DUTY,
        SEL_PER,
        SEL_CNT
    } reg_sel_e;

    typedef enum logic {
        PH_IDLE,
        PH_RUN
    } phase_e;

    typedef struct packed {
        logic en;
        logic pol;
    } ctl_flags_t;

    function automatic reg_sel_e decode_addr(input logic [BUS_AW-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_CTRL: s = SEL_CTRL;
            OFS_STAT: s = SEL_STAT;
            OFS_DUTY: s = SEL_DUTY;
            OFS_PER:  s = SEL_PER;
            OFS_CNT:  s = SEL_CNT;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [BUS_DW-1:0] sat_value(input logic [BUS_DW-1:0] v,
                                                    input logic [BUS_DW-1:0] lim);
        return (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/spwm_fifo.sv
module spwm_fifo #(
    parameter int DW     = 16,
    parameter int DEPTH  = 4,
    parameter int FREE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push,
    input  logic              pop,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     head,
    output logic              empty,
    output logic              full,
    output logic [FREE_W-1:0] free,
    output logic              ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [DW-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0]  wp_q, rp_q;
    logic [FREE_W-1:0] occ_q;
    logic              ovf_q;
    logic              acc_push, acc_pop;

    always_comb begin
        empty    = (occ_q == '0);
        full     = (occ_q == FREE_W'(DEPTH));
        acc_push = push && !full;
        acc_pop  = pop && !empty;
        free     = FREE_W'(DEPTH) - occ_q;
        head     = mem_q[rp_q];
        ovf      = ovf_q;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (acc_push && wp_q == PTR_W'(i)) begin
                mem_q[i] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp_q  <= '0;
            rp_q  <= '0;
            occ_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (acc_push) begin
                wp_q <= (wp_q == LAST_PTR) ? '0 : wp_q + 1'b1;
            end
            if (acc_pop) begin
                rp_q <= (rp_q == LAST_PTR) ? '0 : rp_q + 1'b1;
            end
            occ_q <= occ_q + FREE_W'(acc_push) - FREE_W'(acc_pop);
            if (push && full) begin
                ovf_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/spwm_core.sv
module spwm_core
    import spwm_pkg::*;
#(
    parameter int PRE_W = 4,
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  ctl_flags_t       flags,
    input  logic [PRE_W-1:0] pre,
    input  logic [PER_W-1:0] per,
    input  logic [PER_W-1:0] head,
    input  logic             empty,
    output logic             pop,
    output logic [PER_W-1:0] cnt,
    output logic [PER_W-1:0] duty,
    output logic             pwm
);
    phase_e           phase_q;
    logic [PRE_W-1:0] psc_q;
    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] duty_q;
    logic             tick, at_end, active;

    always_comb begin
        tick   = (psc_q == pre);
        at_end = ({1'b0, cnt_q} >= ({1'b0, per} + (PER_W+1)'(1)));
        pop    = flags.en && !clr && !empty &&
                 ((phase_q == PH_IDLE) || (tick && at_end));
        active = (cnt_q < duty_q);
        pwm    = (flags.en && phase_q == PH_RUN) ? (active ^ flags.pol) : 1'b0;
        cnt    = cnt_q;
        duty   = duty_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= PH_IDLE;
            psc_q   <= '0;
            cnt_q   <= '0;
            duty_q  <= '0;
        end else if (!flags.en) begin
            phase_q <= PH_IDLE;
            psc_q   <= '0;
            cnt_q   <= '0;
        end else if (phase_q == PH_IDLE) begin
            phase_q <= PH_RUN;
            if (!empty) begin
                duty_q <= head;
            end
        end else if (tick) begin
            psc_q <= '0;
            if (at_end) begin
                cnt_q <= '0;
                if (!empty) begin
                    duty_q <= head;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            psc_q <= psc_q + 1'b1;
        end
    end
endmodule

// File: rtl/spwm_regs.sv
module spwm_regs
    import spwm_pkg::*;
#(
    parameter int PRE_W   = 4,
    parameter int PER_W   = 16,
    parameter int PER_MAX = 65533,
    parameter int FREE_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [FREE_W-1:0] fifo_free,
    input  logic              fifo_ovf,
    input  logic [PER_W-1:0]  live_cnt,
    input  logic [PER_W-1:0]  live_duty,
    output ctl_flags_t        flags,
    output logic [PRE_W-1:0]  pre,
    output logic [PER_W-1:0]  per,
    output logic              soft_clr,
    output logic              push,
    output logic [PER_W-1:0]  push_data
);
    localparam logic [BUS_DW-1:0] PER_LIM = BUS_DW'(PER_MAX);

    ctl_flags_t       flags_q;
    logic [PRE_W-1:0] pre_q;
    logic [PER_W-1:0] per_q;
    logic             srst_q;
    reg_sel_e         sel;
    logic             wr;

    always_comb begin
        sel       = decode_addr(bus_addr);
        wr        = bus_valid && bus_write && !srst_q;
        push      = wr && (sel == SEL_DUTY);
        push_data = bus_wdata[PER_W-1:0];
        flags     = flags_q;
        pre       = pre_q;
        per       = per_q;
        soft_clr  = srst_q;
    end

    always_ff @(posedge clk) begin
        if (rst || srst_q) begin
            flags_q <= '0;
            pre_q   <= '0;
            per_q   <= '0;
            srst_q  <= 1'b0;
        end else if (wr) begin
            case (sel)
                SEL_CTRL: begin
                    if (bus_wdata[CTL_SRST_BIT]) begin
                        srst_q <= 1'b1;
                    end else begin
                        flags_q.en  <= bus_wdata[CTL_EN_BIT];
                        flags_q.pol <= bus_wdata[CTL_POL_BIT];
                        pre_q       <= bus_wdata[CTL_PRE_LSB +: PRE_W];
                    end
                end
                SEL_PER: per_q <= PER_W'(sat_value(bus_wdata, PER_LIM));
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CTRL: begin
                bus_rdata[CTL_EN_BIT]             = flags_q.en;
                bus_rdata[CTL_POL_BIT]            = flags_q.pol;
                bus_rdata[CTL_SRST_BIT]           = srst_q;
                bus_rdata[CTL_PRE_LSB +: PRE_W]   = pre_q;
            end
            SEL_STAT: begin
                bus_rdata[STA_OVF_BIT]            = fifo_ovf;
                bus_rdata[STA_FREE_LSB +: FREE_W] = fifo_free;
            end
            SEL_DUTY: bus_rdata[PER_W-1:0] = live_duty;
            SEL_PER:  bus_rdata[PER_W-1:0] = per_q;
            SEL_CNT:  bus_rdata[PER_W-1:0] = live_cnt;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sampled_pwm.sv
module sampled_pwm
    import spwm_pkg::*;
#(
    parameter int PRE_W   = 4,
    parameter int PER_W   = 16,
    parameter int PER_MAX = 65533,
    parameter int DEPTH   = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        pwm_out
);
    localparam int FREE_W = $clog2(DEPTH + 1);

    ctl_flags_t        flags;
    logic [PRE_W-1:0]  pre_val;
    logic [PER_W-1:0]  per_val;
    logic              soft_clr;
    logic              duty_push;
    logic [PER_W-1:0]  push_data;
    logic [PER_W-1:0]  fifo_head;
    logic              fifo_empty, fifo_full, fifo_ovf, fifo_pop;
    logic [FREE_W-1:0] fifo_free;
    logic [PER_W-1:0]  cnt_val, duty_val;

    spwm_regs #(
        .PRE_W(PRE_W), .PER_W(PER_W), .PER_MAX(PER_MAX), .FREE_W(FREE_W)
    ) u_regs (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fifo_free(fifo_free), .fifo_ovf(fifo_ovf),
        .live_cnt(cnt_val), .live_duty(duty_val),
        .flags(flags), .pre(pre_val), .per(per_val),
        .soft_clr(soft_clr), .push(duty_push), .push_data(push_data)
    );

    spwm_fifo #(
        .DW(PER_W), .DEPTH(DEPTH), .FREE_W(FREE_W)
    ) u_fifo (
        .clk(clk), .rst(rst), .clr(soft_clr),
        .push(duty_push), .pop(fifo_pop), .wdata(push_data),
        .head(fifo_head), .empty(fifo_empty), .full(fifo_full),
        .free(fifo_free), .ovf(fifo_ovf)
    );

    spwm_core #(
        .PRE_W(PRE_W), .PER_W(PER_W)
    ) u_core (
        .clk(clk), .rst(rst), .clr(soft_clr),
        .flags(flags), .pre(pre_val), .per(per_val),
        .head(fifo_head), .empty(fifo_empty), .pop(fifo_pop),
        .cnt(cnt_val), .duty(duty_val), .pwm(pwm_out)
    );
endmodule

// File: rtl/spwm_chk.sv
module spwm_chk #(
    parameter int DEPTH   = 4,
    parameter int PER_W   = 16,
    parameter int PER_MAX = 65533,
    parameter int FREE_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              soft_clr,
    input logic              push,
    input logic              fifo_full,
    input logic              fifo_ovf,
    input logic [FREE_W-1:0] fifo_free,
    input logic [PER_W-1:0]  cnt,
    input logic [PER_W-1:0]  duty,
    input logic [PER_W-1:0]  per
);
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> cnt == '0); // R5

    AST_DUTY_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
        !$stable(duty) |-> cnt == '0); // R10

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(fifo_ovf) && !$past(soft_clr)) |-> fifo_ovf); // R9

    AST_FULL_SETS_OVF: assert property (@(posedge clk) disable iff (rst)
        (push && fifo_full) |=> fifo_ovf); // R9

    AST_SRST_PULSE: assert property (@(posedge clk) disable iff (rst)
        soft_clr |=> !soft_clr); // R7

    AST_FREE_RANGE: assert property (@(posedge clk) disable iff (rst)
        fifo_free <= FREE_W'(DEPTH)); // R8

    AST_PER_CLAMP: assert property (@(posedge clk) disable iff (rst)
        per <= PER_W'(PER_MAX)); // R3
endmodule

bind sampled_pwm spwm_chk #(
    .DEPTH(DEPTH), .PER_W(PER_W), .PER_MAX(PER_MAX), .FREE_W(FREE_W)
) u_chk (
    .clk(clk), .rst(rst), .en(flags.en), .soft_clr(soft_clr),
    .push(duty_push), .fifo_full(fifo_full), .fifo_ovf(fifo_ovf),
    .fifo_free(fifo_free), .cnt(cnt_val), .duty(duty_val), .per(per_val)
);

// File: tb/test_sampled_pwm.sv
module test_sampled_pwm;
    localparam logic [4:0] A_CTRL = 5'h00;
    localparam logic [4:0] A_STAT = 5'h04;
    localparam logic [4:0] A_DUTY = 5'h0C;
    localparam logic [4:0] A_PER  = 5'h10;
    localparam logic [4:0] A_CNT  = 5'h14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int vecs = 0;
    int bad  = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sampled_pwm i_sampled_pwm (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // returns at the first falling edge where the counter has just restarted at 0
    task automatic sync_start();
        logic [31:0] c;
        do begin @(negedge clk); rd(A_CNT, c); end while (c == 0);
        do begin @(negedge clk); rd(A_CNT, c); end while (c != 0);
    endtask

    // counts active samples over n clocks, the current one included
    task automatic meas(input int n, output int h);
        h = pwm_out ? 1 : 0;
        for (int i = 1; i < n; i++) begin
            @(negedge clk);
            #1;
            if (pwm_out) h++;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
        rd(A_PER, d);  chk("R1 period", d, 32'h0);
        rd(A_STAT, d); chk("R1 status", d, 32'h40);
        chk("R1 output", {31'b0, pwm_out}, 32'h0);
    endtask

    task automatic t_clamp();
        logic [31:0] d;
        wr(A_PER, 32'hFFFF_FFFF); rd(A_PER, d); chk("R3 clamp", d, 32'hFFFD);
        wr(A_PER, 32'h0000_FFFD); rd(A_PER, d); chk("R3 at max", d, 32'hFFFD);
        wr(A_PER, 32'd10);        rd(A_PER, d); chk("R3 small", d, 32'd10);
    endtask

    task automatic t_soft_reset();
        logic [31:0] d;
        wr(A_DUTY, 32'd7); wr(A_DUTY, 32'd7);
        rd(A_STAT, d); chk("R8 two queued", d, 32'h20);
        wr(A_CTRL, 32'h2);
        wr(A_CTRL, 32'h8);
        rd(A_CTRL, d); chk("R7 bit set one cycle", (d >> 3) & 1, 32'h1);
        @(negedge clk);
        rd(A_CTRL, d); chk("R7 self-clear", d, 32'h0);
        rd(A_STAT, d); chk("R7 queue flushed", d, 32'h40);
        rd(A_PER, d);  chk("R7 period default", d, 32'h0);
    endtask

    task automatic t_overflow_order();
        logic [31:0] d;
        int h;
        wr(A_PER, 32'd10);
        wr(A_DUTY, 32'd1); wr(A_DUTY, 32'd2); wr(A_DUTY, 32'd3); wr(A_DUTY, 32'd4);
        rd(A_STAT, d); chk("R8 full", d, 32'h00);
        wr(A_DUTY, 32'd9);
        rd(A_STAT, d); chk("R9 overflow flag", d, 32'h01);
        wr(A_CTRL, 32'h1);
        sync_start();
        meas(12, h); chk("R11 second entry", h, 2);
        @(negedge clk); #1; meas(12, h); chk("R11 third entry", h, 3);
        @(negedge clk); #1; meas(12, h); chk("R11 fourth entry", h, 4);
        @(negedge clk); #1; meas(12, h); chk("R9 dropped write unseen", h, 4);
        rd(A_STAT, d); chk("R9 sticky after drain", d, 32'h41);
    endtask

    task automatic t_period_length();
        logic [31:0] d;
        sync_start();
        for (int i = 1; i <= 11; i++) begin
            @(negedge clk); rd(A_CNT, d); chk("R2 count step", d, i);
        end
        @(negedge clk); rd(A_CNT, d); chk("R2 wrap after P+1", d, 0);
    endtask

    task automatic t_boundary();
        logic [31:0] d;
        int h;
        sync_start();
        fork
            meas(12, h);
            begin
                repeat (3) @(negedge clk);
                wr(A_DUTY, 32'd1);
                rd(A_DUTY, d);
            end
        join
        chk("R10 running cycle untouched", h, 4);
        chk("R10 duty read before edge", d, 4);
        @(negedge clk); #1; meas(12, h); chk("R10 applied next cycle", h, 1);
    endtask

    task automatic t_extremes();
        int h;
        wr(A_DUTY, 32'd0);   sync_start(); meas(12, h); chk("R12 duty zero", h, 0);
        wr(A_DUTY, 32'd12);  sync_start(); meas(12, h); chk("R12 duty P+2", h, 12);
        wr(A_DUTY, 32'd200); sync_start(); meas(12, h); chk("R12 duty large", h, 12);
        wr(A_DUTY, 32'd11);  sync_start(); meas(12, h); chk("R12 duty P+1", h, 11);
    endtask

    task automatic t_polarity();
        int h;
        wr(A_CTRL, 32'h3);
        sync_start(); meas(12, h); chk("R6 inverted", h, 1);
        wr(A_DUTY, 32'd3);
        sync_start(); meas(12, h); chk("R6 inverted duty 3", h, 9);
    endtask

    task automatic t_disable();
        logic [31:0] d;
        int h;
        wr(A_CTRL, 32'h2);
        wr(A_DUTY, 32'd5);
        @(negedge clk); #1;
        meas(20, h); chk("R5 output low", h, 0);
        rd(A_CNT, d); chk("R5 counter held", d, 0);
    endtask

    task automatic t_prescale();
        logic [31:0] d;
        int h;
        wr(A_CTRL, 32'h8);
        wr(A_PER, 32'd2);
        wr(A_DUTY, 32'd2);
        wr(A_CTRL, 32'h201);
        sync_start();
        repeat (2) @(negedge clk);
        rd(A_CNT, d); chk("R4 count held three clocks", d, 0);
        @(negedge clk);
        rd(A_CNT, d); chk("R4 count steps", d, 1);
        sync_start(); meas(12, h); chk("R4 divided duty", h, 6);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_clamp();
        t_soft_reset();
        t_overflow_order();
        t_period_length();
        t_boundary();
        t_extremes();
        t_polarity();
        t_disable();
        t_prescale();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vecs++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end
endmodule